// File: doc/BRIEF.md
# Bidirectional GPIO Port with Latch Readback

An eight-pin general-purpose I/O port that sits on a small register bus. Each pin has a direction bit and a shared output latch bit. A pin configured as an output drives its latch bit onto the pad. A pin configured as an input leaves its driver off and may enable a weak pull-up. Incoming pin levels pass through a two-flop synchronizer before the bus or the change detector sees them.

Two bus addresses reach the same output latch. A read of the pin address returns the synchronized pad levels, so an output that an external device overpowers reads back as the level actually on the pad. A read of the latch address returns the stored value, whatever the pads carry.

The upper four pins feed a change detector. It compares their synchronized levels against a snapshot that is taken on every read of the pin address. A difference on an input pin sets a sticky flag. An enable bit turns that flag into an interrupt request. As an elaboration option, one chosen pin can act as open-drain.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFF, the control register reads 0x01, and `pin_oe_o`, `pin_out_o`, `pin_pu_o` and `irq_o` are all 0.
- R2: Address 1 is the direction register. A 0 in bit n sets `pin_oe_o[n]`=1 and drives latch bit n on `pin_out_o[n]`. A 1 in bit n clears `pin_oe_o[n]`. The change is visible one cycle after the write.
- R3: Writes to address 0 (pin) and to address 2 (latch) both update one shared latch, and either one is visible on the latch read and on the pin outputs.
- R4: A read of address 2 returns the latch contents, independent of `pin_i`.
- R5: A read of address 0 returns `pin_i` delayed by two clock edges.
- R6: Control bit 0 is an active-low global pull-up enable. With it at 0, `pin_pu_o[n]`=1 for every input pin. With it at 1, all pull-ups are off.
- R7: `pin_pu_o[n]` is 0 whenever pin n is an output, and is never high together with `pin_oe_o[n]`.
- R8: Control bit 1 is the change flag. It sets one cycle after a synchronized level on an input pin among bits 7..4 differs from the snapshot. Changes on bits 3..0, or on pins configured as outputs, leave it clear.
- R9: The flag stays set until a control write with bit 1 at 0 clears it. Writing 1 to bit 1 has no effect. If the mismatch still exists at the clear, the flag sets again on the next clock. Each read of address 0 reloads the snapshot.
- R10: Control bit 2 is the change-interrupt enable. `irq_o` is 1 exactly when both the flag and this enable are 1.
- R11: When `OD_EN`=1, pin `OD_PIN` is open-drain. `pin_out_o` for that pin is always 0, and `pin_oe_o` for that pin is 1 only when its direction bit is 0 and its latch bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 pin, 1 direction, 2 latch, 3 control |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; on address 0 it reloads the change snapshot |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 8 | Asynchronous pad levels |
| pin_oe_o | output | 8 | Per-pin output driver enable |
| pin_out_o | output | 8 | Per-pin output value |
| pin_pu_o | output | 8 | Per-pin weak pull-up enable |
| irq_o | output | 1 | Change interrupt request |

## Verification
The bench builds the port with `OD_EN`=1 and `OD_PIN`=1. This places the open-drain pin outside the change-detect nibble, so its drive and release rules can be checked alone while the upper pins stay push-pull. With that variant the bench checks the split between the latch readback and the pad readback while an external level opposes the driven value. It also checks how the change flag interacts with the snapshot reload, including a clear that loses to a persisting mismatch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 2'd0,
    REG_DIR  = 2'd1,
    REG_LAT  = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_PU_OFF = 0;
  localparam int unsigned CTRL_FLAG   = 1;
  localparam int unsigned CTRL_IEN    = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_sync_i,
  input  logic              flag_i,
  output logic [W-1:0]      lat_o,
  output logic [W-1:0]      dir_o,
  output logic              pu_off_o,
  output logic              ien_o,
  output logic              flag_clr_o,
  output logic              snap_ld_o
);
  logic [W-1:0] lat_q, dir_q;
  logic         pu_off_q, ien_q;
  logic         wr_lat, wr_dir, wr_ctrl;

  assign wr_lat  = wr_en_i && (addr_i == REG_PIN || addr_i == REG_LAT);
  assign wr_dir  = wr_en_i && (addr_i == REG_DIR);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      dir_q    <= '1;
      pu_off_q <= 1'b1;
      ien_q    <= 1'b0;
    end else begin
      if (wr_lat) lat_q <= wdata_i;
      if (wr_dir) dir_q <= wdata_i;
      if (wr_ctrl) begin
        pu_off_q <= wdata_i[CTRL_PU_OFF];
        ien_q    <= wdata_i[CTRL_IEN];
      end
    end
  end

  // flag is write-0-to-clear; a 1 leaves it alone
  assign flag_clr_o = wr_ctrl && !wdata_i[CTRL_FLAG];
  assign snap_ld_o  = rd_en_i && (addr_i == REG_PIN);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_PIN:  rdata_o = pin_sync_i;
      REG_DIR:  rdata_o = dir_q;
      REG_LAT:  rdata_o = lat_q;
      REG_CTRL: begin
        rdata_o[CTRL_PU_OFF] = pu_off_q;
        rdata_o[CTRL_FLAG]   = flag_i;
        rdata_o[CTRL_IEN]    = ien_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign lat_o    = lat_q;
  assign dir_o    = dir_q;
  assign pu_off_o = pu_off_q;
  assign ien_o    = ien_q;
endmodule

// File: rtl/gpio_ioc.sv
module gpio_ioc #(
  parameter int unsigned NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] lvl_i,
  input  logic [NB-1:0] is_in_i,
  input  logic          snap_ld_i,
  input  logic          flag_clr_i,
  input  logic          ien_i,
  output logic          flag_o,
  output logic          irq_o
);
  logic [NB-1:0] snap_q, diff;
  logic          flag_q;

  assign diff = (lvl_i ^ snap_q) & is_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (snap_ld_i) snap_q <= lvl_i;
      if (flag_clr_i)  flag_q <= 1'b0;
      else if (|diff)  flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W      = 8,
  parameter bit          OD_EN  = 1'b0,
  parameter int unsigned OD_PIN = 0
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic         pu_off_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (OD_EN && i == OD_PIN) begin : g_od
      assign oe_o[i]  = !dir_i[i] && !lat_i[i];
      assign out_o[i] = 1'b0;
    end else begin : g_pp
      assign oe_o[i]  = !dir_i[i];
      assign out_o[i] = lat_i[i];
    end
    assign pu_o[i] = dir_i[i] && !pu_off_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W      = PORT_W,
  parameter int unsigned IOC_LO = 4,
  parameter bit          OD_EN  = 1'b0,
  parameter int unsigned OD_PIN = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_oe_o,
  output logic [W-1:0]      pin_out_o,
  output logic [W-1:0]      pin_pu_o,
  output logic              irq_o
);
  localparam int unsigned NB = W - IOC_LO;

  logic [W-1:0] pin_sync, lat, dir;
  logic         pu_off, ioc_en, ioc_flag, flag_clr, snap_ld;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_sync_i(pin_sync),
    .flag_i    (ioc_flag),
    .lat_o     (lat),
    .dir_o     (dir),
    .pu_off_o  (pu_off),
    .ien_o     (ioc_en),
    .flag_clr_o(flag_clr),
    .snap_ld_o (snap_ld)
  );

  gpio_ioc #(.NB(NB)) u_ioc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (pin_sync[W-1:IOC_LO]),
    .is_in_i   (dir[W-1:IOC_LO]),
    .snap_ld_i (snap_ld),
    .flag_clr_i(flag_clr),
    .ien_i     (ioc_en),
    .flag_o    (ioc_flag),
    .irq_o     (irq_o)
  );

  gpio_pad_ctrl #(.W(W), .OD_EN(OD_EN), .OD_PIN(OD_PIN)) u_pad (
    .dir_i   (dir),
    .lat_i   (lat),
    .pu_off_i(pu_off),
    .oe_o    (pin_oe_o),
    .out_o   (pin_out_o),
    .pu_o    (pin_pu_o)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          OD_EN  = 1'b0,
  parameter int unsigned OD_PIN = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rdata_i,
  input logic [W-1:0]      oe_i,
  input logic [W-1:0]      out_i,
  input logic [W-1:0]      pu_i,
  input logic              irq_i,
  input logic              flag_i,
  input logic              ien_i
);
  localparam logic [W-1:0] PP = OD_EN ? ~(W'(1) << OD_PIN) : '1;

  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == REG_DIR |=> (oe_i & PP) == (~$past(wdata_i) & PP)); // R2

  AST_SHARED_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == REG_PIN || addr_i == REG_LAT)
      |=> (out_i & PP) == ($past(wdata_i) & PP)); // R3

  AST_LATCH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == REG_LAT |-> (rdata_i & PP) == (out_i & PP)); // R4

  AST_PU_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_i & oe_i) == '0); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !(wr_en_i && addr_i == REG_CTRL && !wdata_i[CTRL_FLAG]) |=> flag_i); // R9

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i && ien_i); // R10

  AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && ien_i |-> irq_i); // R10

  if (OD_EN) begin : g_od_chk
    AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_i[OD_PIN]); // R11
  end
endmodule

bind gpio_port gpio_port_chk #(.W(W), .OD_EN(OD_EN), .OD_PIN(OD_PIN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .wdata_i(wdata_i),
  .rdata_i(rdata_o),
  .oe_i   (pin_oe_o),
  .out_i  (pin_out_o),
  .pu_i   (pin_pu_o),
  .irq_i  (irq_o),
  .flag_i (ioc_flag),
  .ien_i  (ioc_en)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int unsigned W      = 8;
  localparam int unsigned OD_PIN = 1;
  localparam logic [W-1:0] ODM   = 8'h02;
  localparam logic [1:0] A_PIN = 2'd0, A_DIR = 2'd1, A_LAT = 2'd2, A_CTRL = 2'd3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wdata = '0, pin = '0;
  logic [W-1:0] rdata, oe, pout, pu;
  logic         irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_port #(.W(W), .IOC_LO(4), .OD_EN(1'b1), .OD_PIN(OD_PIN)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_oe_o(oe),
    .pin_out_o(pout), .pin_pu_o(pu), .irq_o(irq)
  );

  function automatic logic [W-1:0] exp_oe(logic [W-1:0] d, logic [W-1:0] l);
    return ~d & ~(ODM & l);
  endfunction
  function automatic logic [W-1:0] exp_out(logic [W-1:0] l);
    return l & ~ODM;
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    #1;
    chk("R1 oe", oe, 8'h00);
    chk("R1 out", pout, 8'h00);
    chk("R1 pu", pu, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(A_LAT, d);  chk("R1 latch", d, 8'h00);
    rd(A_DIR, d);  chk("R1 dir", d, 8'hFF);
    rd(A_CTRL, d); chk("R1 ctrl", d, 8'h01);
  endtask

  task automatic t_drive();
    logic [W-1:0] d;
    wr(A_DIR, 8'hF0);
    wr(A_PIN, 8'h33);
    #1 chk("R2 oe", oe, exp_oe(8'hF0, 8'h33));
    chk("R3 out via pin addr", pout, exp_out(8'h33));
    wr(A_LAT, 8'hCC);
    #1 chk("R3 out via latch addr", pout, exp_out(8'hCC));
    wr(A_PIN, 8'h5A);
    rd(A_LAT, d); chk("R3 latch read after pin write", d, 8'h5A);
    wr(A_DIR, 8'h00); wr(A_LAT, 8'h00);
    #1 chk("R11 od drives low", {6'd0, oe[OD_PIN], pout[OD_PIN]}, 8'h02);
    wr(A_LAT, 8'h02);
    #1 chk("R11 od releases", {6'd0, oe[OD_PIN], pout[OD_PIN]}, 8'h00);
    chk("R2 all outputs", oe, exp_oe(8'h00, 8'h02));
  endtask

  task automatic t_readback();
    logic [W-1:0] d;
    wr(A_DIR, 8'h00); wr(A_LAT, 8'hA5);
    pin = 8'h5A; settle();
    rd(A_LAT, d); chk("R4 latch ignores pads", d, 8'hA5);
    rd(A_PIN, d); chk("R5 pads read", d, 8'h5A);
    @(negedge clk); addr = A_PIN; pin = 8'h3C;
    @(negedge clk); #1 chk("R5 one edge old", rdata, 8'h5A);
    @(negedge clk); #1 chk("R5 two edges new", rdata, 8'h3C);
  endtask

  task automatic t_pullup();
    wr(A_CTRL, 8'h00); wr(A_DIR, 8'hF0);
    #1 chk("R6 R7 pu inputs only", pu, 8'hF0);
    wr(A_DIR, 8'h00);
    #1 chk("R7 pu off outputs", pu, 8'h00);
    wr(A_DIR, 8'hFF); wr(A_CTRL, 8'h01);
    #1 chk("R6 global off", pu, 8'h00);
  endtask

  task automatic t_ioc();
    logic [W-1:0] d;
    pin = 8'h00; wr(A_DIR, 8'hFF); settle();
    rd(A_PIN, d); wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); chk("R9 cleared", d, 8'h01);
    pin = 8'h0F; settle();
    rd(A_CTRL, d); chk("R8 low nibble ignored", d, 8'h01);
    wr(A_DIR, 8'h0F); pin = 8'hFF; settle();
    rd(A_CTRL, d); chk("R8 output pins ignored", d, 8'h01);
    wr(A_DIR, 8'hFF);
    rd(A_CTRL, d); chk("R8 input change sets flag", d, 8'h03);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); chk("R9 persisting mismatch resets flag", d, 8'h03);
    rd(A_PIN, d); wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); chk("R9 clear after snapshot", d, 8'h01);
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, d); chk("R9 write one no effect", d, 8'h01);
  endtask

  task automatic t_irq();
    logic [W-1:0] d;
    wr(A_CTRL, 8'h05);
    #1 chk("R10 no flag no irq", {7'd0, irq}, 8'h00);
    pin = 8'h7F; settle();
    chk("R10 irq raised", {7'd0, irq}, 8'h01);
    rd(A_CTRL, d); chk("R10 ctrl", d, 8'h07);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); chk("R10 flag held", d, 8'h03);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_readback();
    t_pullup();
    t_ioc();
    t_irq();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule